// File: doc/BRIEF.md
# Bus-Mapped Seconds Counter with Alarm

This peripheral keeps a 32-bit count of seconds and raises an alarm when that count reaches a programmed value. It sits on an APB-style slave port inside a 4 KB address window. The count advances by one on each seconds tick. The tick comes from one of two sources, chosen by a parameter: an internal prescaler that divides the bus clock, or a one-cycle enable pulse on an input pin. Software can load the count with any value at any time. When the count wraps past its top value it returns to zero.

The alarm is an event that sets a sticky raw status flag. A mask bit gates that flag onto a level interrupt line. A write of any data to the clear register drops the flag. A load or match write that makes the count equal the match value at that moment fires the alarm at once. The alarm does not wait a full wrap. A small identification window at the top of the address space returns one fixed byte per word.

Top module: `rtcc_top`

## Requirements
- R1: The count increments by exactly one on every cycle in which the selected tick is high, and steps from 0xFFFFFFFF to 0. With no tick and no load write, the count holds. The count reads at offset 0x000.
- R2: With USE_EXT_TICK = 0, a tick occurs once every TICK_DIV bus clocks. The first tick comes on the TICK_DIV-th clock edge after reset is released, so the count equals floor(edges / TICK_DIV). With USE_EXT_TICK = 1, the `ext_tick` pin is the tick.
- R3: A write to offset 0x008 sets the count to the written value from the next cycle. Reading 0x008 returns the last value written there.
- R4: Offset 0x004 holds a read/write match value. Raw status (bit 0 of offset 0x014) sets one cycle after a tick brings the count equal to the match value. It sets only when the count moves into equality, and not again while the count is unchanged.
- R5: A load write or match write that leaves the count equal to the match value sets raw status one cycle later.
- R6: Only bit 0 of a write to offset 0x010 is stored. `irq` and bit 0 of offset 0x018 both equal raw status AND that mask bit.
- R7: A write of any data to offset 0x01C clears raw status, including a write of zero.
- R8: When an alarm set and a clear write fall in the same cycle, the set wins and raw status stays 1.
- R9: Offset 0x00C always reads 1, and writes to it have no effect.
- R10: Writes to offsets 0x000, 0x014 and 0x018 change nothing. Reads of 0x01C and of any offset with no register (for example 0x020 or 0x800) return 0.
- R11: Offsets 0xFE0 to 0xFFC each return one byte in bits [7:0], indexed by (offset − 0xFE0) >> 2. The bytes in index order are 0x31, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R12: `pready` is always 1 and `pslverr` is always 0.
- R13: After reset, the count, match, load, mask and raw status all read 0, `irq` is 0, and the prescaler restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte address within the window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| pready | output | 1 | Transfer complete (always 1) |
| pslverr | output | 1 | Error response (always 0) |
| ext_tick | input | 1 | External seconds-tick enable pulse |
| irq | output | 1 | Level interrupt, raw status AND mask |

## Verification
The bench drives the count across 0xFFFFFFFF. A design that saturated or reset there would read a wrong value after the tick.

It programs a match equal to the current count through both the load and the match register. An alarm that only fires on a tick edge would leave raw status at 0.

It holds the count at the match value after a clear to show the flag does not set again. A level compare would set it again at once.

It lines up a tick-driven set with a clear write in the same cycle. A design that gave the clear priority would lose the alarm. The bench also clears with zero data to catch a design that looks at bit 0. It writes to the read-only registers, to catch a design that accepts those writes.

// File: rtl/rtcc_pkg.sv
package rtcc_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 12;
    localparam int ID_LEN = 8;
    localparam int ID_IDX_W = $clog2(ID_LEN);

    localparam logic [ADDR_W-1:0] OFS_COUNT  = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_MATCH  = 12'h004;
    localparam logic [ADDR_W-1:0] OFS_LOAD   = 12'h008;
    localparam logic [ADDR_W-1:0] OFS_CTRL   = 12'h00C;
    localparam logic [ADDR_W-1:0] OFS_MASK   = 12'h010;
    localparam logic [ADDR_W-1:0] OFS_RAW    = 12'h014;
    localparam logic [ADDR_W-1:0] OFS_MASKED = 12'h018;
    localparam logic [ADDR_W-1:0] OFS_CLEAR  = 12'h01C;
    localparam logic [ADDR_W-1:0] OFS_ID     = 12'hFE0;

    typedef enum logic [3:0] {
        SEL_COUNT,
        SEL_MATCH,
        SEL_LOAD,
        SEL_CTRL,
        SEL_MASK,
        SEL_RAW,
        SEL_MASKED,
        SEL_CLEAR,
        SEL_ID,
        SEL_NONE
    } reg_sel_e;

    // Write requests produced by the bus decoder, one cycle wide.
    typedef struct packed {
        logic              load_wr;
        logic              match_wr;
        logic              mask_wr;
        logic              clear_wr;
        logic [DATA_W-1:0] data;
    } wr_req_t;

    // Architectural state presented to the read mux.
    typedef struct packed {
        logic [DATA_W-1:0] count;
        logic [DATA_W-1:0] match;
        logic [DATA_W-1:0] load;
        logic              mask;
        logic              raw;
    } rd_view_t;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        reg_sel_e s;
        if (a >= OFS_ID && a[1:0] == 2'b00) begin
            s = SEL_ID;
        end else begin
            case (a)
                OFS_COUNT:  s = SEL_COUNT;
                OFS_MATCH:  s = SEL_MATCH;
                OFS_LOAD:   s = SEL_LOAD;
                OFS_CTRL:   s = SEL_CTRL;
                OFS_MASK:   s = SEL_MASK;
                OFS_RAW:    s = SEL_RAW;
                OFS_MASKED: s = SEL_MASKED;
                OFS_CLEAR:  s = SEL_CLEAR;
                default:    s = SEL_NONE;
            endcase
        end
        return s;
    endfunction

    function automatic logic [7:0] id_byte(input logic [ID_IDX_W-1:0] idx);
        logic [7:0] b;
        case (idx)
            3'd0:    b = 8'h31;
            3'd1:    b = 8'h10;
            3'd2:    b = 8'h14;
            3'd3:    b = 8'h00;
            3'd4:    b = 8'h0D;
            3'd5:    b = 8'hF0;
            3'd6:    b = 8'h05;
            default: b = 8'hB1;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/rtcc_tick_gen.sv
module rtcc_tick_gen #(
    parameter bit USE_EXT_TICK = 1'b0,
    parameter int TICK_DIV     = 32768
) (
    input  logic clk,
    input  logic rst,
    input  logic ext_tick,
    output logic tick
);
    localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

    logic [CW-1:0] div_q;
    logic          div_tick;

    assign div_tick = (div_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= '0;
        end else if (div_tick) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    assign tick = USE_EXT_TICK ? ext_tick : div_tick;

endmodule

// File: rtl/rtcc_bus_if.sv
module rtcc_bus_if
    import rtcc_pkg::*;
(
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    input  rd_view_t          view,
    output wr_req_t           req,
    output logic [DATA_W-1:0] prdata
);
    reg_sel_e sel;
    logic     wr_acc;

    assign sel    = decode_addr(paddr);
    assign wr_acc = psel & penable & pwrite;

    always_comb begin
        req          = '0;
        req.data     = pwdata;
        req.load_wr  = wr_acc && (sel == SEL_LOAD);
        req.match_wr = wr_acc && (sel == SEL_MATCH);
        req.mask_wr  = wr_acc && (sel == SEL_MASK);
        req.clear_wr = wr_acc && (sel == SEL_CLEAR);
    end

    always_comb begin
        prdata = '0;
        if (psel && !pwrite) begin
            case (sel)
                SEL_COUNT:  prdata = view.count;
                SEL_MATCH:  prdata = view.match;
                SEL_LOAD:   prdata = view.load;
                SEL_CTRL:   prdata = DATA_W'(1);
                SEL_MASK:   prdata = DATA_W'(view.mask);
                SEL_RAW:    prdata = DATA_W'(view.raw);
                SEL_MASKED: prdata = DATA_W'(view.raw & view.mask);
                SEL_ID:     prdata = DATA_W'(id_byte(paddr[ID_IDX_W+1:2]));
                default:    prdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/rtcc_counter.sv
module rtcc_counter
    import rtcc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              load_wr,
    input  logic [DATA_W-1:0] load_val,
    output logic [DATA_W-1:0] count_q,
    output logic [DATA_W-1:0] load_q,
    output logic              moved_q
);
    // moved_q marks a cycle whose count was freshly written or advanced.
    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
            load_q  <= '0;
            moved_q <= 1'b0;
        end else if (load_wr) begin
            count_q <= load_val;
            load_q  <= load_val;
            moved_q <= 1'b1;
        end else if (tick) begin
            count_q <= count_q + 1'b1;
            moved_q <= 1'b1;
        end else begin
            moved_q <= 1'b0;
        end
    end

endmodule

// File: rtl/rtcc_alarm.sv
module rtcc_alarm
    import rtcc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  wr_req_t           req,
    input  logic [DATA_W-1:0] count,
    input  logic              moved,
    output logic [DATA_W-1:0] match_q,
    output logic              mask_q,
    output logic              raw_q,
    output logic              set_evt,
    output logic              irq
);
    logic retarget_q;

    // Compare only in a cycle after the count or match changed.
    assign set_evt = (moved | retarget_q) && (count == match_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            match_q    <= '0;
            mask_q     <= 1'b0;
            raw_q      <= 1'b0;
            retarget_q <= 1'b0;
        end else begin
            retarget_q <= req.match_wr;
            if (req.match_wr) match_q <= req.data;
            if (req.mask_wr)  mask_q  <= req.data[0];
            if (set_evt) begin
                raw_q <= 1'b1;
            end else if (req.clear_wr) begin
                raw_q <= 1'b0;
            end
        end
    end

    assign irq = raw_q & mask_q;

endmodule

// File: rtl/rtcc_top.sv
module rtcc_top
    import rtcc_pkg::*;
#(
    parameter bit USE_EXT_TICK = 1'b0,
    parameter int TICK_DIV     = 32768
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic              pready,
    output logic              pslverr,
    input  logic              ext_tick,
    output logic              irq
);
    wr_req_t           req;
    rd_view_t          view;
    logic              tick;
    logic              load_wr;
    logic              clear_wr;
    logic [DATA_W-1:0] wdata;
    logic [DATA_W-1:0] count_q;
    logic [DATA_W-1:0] load_q;
    logic [DATA_W-1:0] match_q;
    logic              moved_q;
    logic              mask_q;
    logic              raw_q;
    logic              set_evt;

    rtcc_tick_gen #(
        .USE_EXT_TICK(USE_EXT_TICK),
        .TICK_DIV    (TICK_DIV)
    ) u_tick (
        .clk     (clk),
        .rst     (rst),
        .ext_tick(ext_tick),
        .tick    (tick)
    );

    rtcc_bus_if u_bus (
        .psel   (psel),
        .penable(penable),
        .pwrite (pwrite),
        .paddr  (paddr),
        .pwdata (pwdata),
        .view   (view),
        .req    (req),
        .prdata (prdata)
    );

    assign load_wr  = req.load_wr;
    assign clear_wr = req.clear_wr;
    assign wdata    = req.data;

    rtcc_counter u_cnt (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .load_wr (load_wr),
        .load_val(wdata),
        .count_q (count_q),
        .load_q  (load_q),
        .moved_q (moved_q)
    );

    rtcc_alarm u_alarm (
        .clk    (clk),
        .rst    (rst),
        .req    (req),
        .count  (count_q),
        .moved  (moved_q),
        .match_q(match_q),
        .mask_q (mask_q),
        .raw_q  (raw_q),
        .set_evt(set_evt),
        .irq    (irq)
    );

    always_comb begin
        view.count = count_q;
        view.match = match_q;
        view.load  = load_q;
        view.mask  = mask_q;
        view.raw   = raw_q;
    end

    assign pready  = 1'b1;
    assign pslverr = 1'b0;

endmodule

// File: rtl/rtcc_checker.sv
module rtcc_checker
    import rtcc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              tick,
    input logic              load_wr,
    input logic              clear_wr,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] count,
    input logic [DATA_W-1:0] match,
    input logic              raw,
    input logic              set_evt
);
    // R1: one step per tick, including the wrap to zero
    a_r1_step: assert property (@(posedge clk) disable iff (rst)
        (tick && !load_wr) |=> (count == $past(count) + 32'd1));

    // R1: hold without tick or load
    a_r1_hold: assert property (@(posedge clk) disable iff (rst)
        (!tick && !load_wr) |=> (count == $past(count)));

    // R3: load takes the bus data
    a_r3_load: assert property (@(posedge clk) disable iff (rst)
        load_wr |=> (count == $past(wdata)));

    // R4: raw status only rises after count equalled match
    a_r4_raise: assert property (@(posedge clk) disable iff (rst)
        $rose(raw) |-> $past(count == match));

    // R7: clear drops raw status when no set competes
    a_r7_clear: assert property (@(posedge clk) disable iff (rst)
        (clear_wr && !set_evt) |=> !raw);

    // R8: a set is never lost to a clear
    a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
        set_evt |=> raw);

    // R13: reset empties count and status
    a_r13_reset: assert property (@(posedge clk)
        rst |=> (count == '0) && !raw);
endmodule

bind rtcc_top rtcc_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .load_wr (load_wr),
    .clear_wr(clear_wr),
    .wdata   (wdata),
    .count   (count_q),
    .match   (match_q),
    .raw     (raw_q),
    .set_evt (set_evt)
);

// File: tb/test_rtcc_top.sv
module test_rtcc_top;
    localparam time CLK_PER = 10ns;
    localparam int  PRE_DIV = 5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready, pslverr, irq;
    logic        ext_tick = 1'b0;

    logic [31:0] prdata_p;
    logic        pready_p, pslverr_p, irq_p;

    int unsigned pass_cnt = 0;
    int unsigned total_cnt = 0;
    int unsigned cyc = 0;
    bit          done = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic [31:0] rd_data;
    event        rd_done;

    always #(CLK_PER/2) clk = ~clk;

    always @(posedge clk) if (!rst) cyc <= cyc + 1;

    rtcc_top #(.USE_EXT_TICK(1'b1), .TICK_DIV(4)) i_rtcc_top (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
        .pslverr(pslverr), .ext_tick(ext_tick), .irq(irq)
    );

    rtcc_top #(.USE_EXT_TICK(1'b0), .TICK_DIV(PRE_DIV)) i_rtcc_top_pre (
        .clk(clk), .rst(rst), .psel(1'b1), .penable(1'b1), .pwrite(1'b0),
        .paddr(12'h000), .pwdata(32'h0), .prdata(prdata_p), .pready(pready_p),
        .pslverr(pslverr_p), .ext_tick(1'b0), .irq(irq_p)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total_cnt++;
        if (act === exp) pass_cnt++;
        else $display("FAIL %s: actual %h expected %h", tag, act, exp);
    endtask

    // Monitor: pops the expected item for every completed read.
    initial begin
        forever begin
            @(rd_done);
            chk(tag_q.pop_front(), rd_data, exp_q.pop_front());
        end
    end

    task automatic apb_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic apb_read(input logic [11:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        #1;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        rd_data = prdata;
        -> rd_done;
        #1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic pulse_tick();
        @(negedge clk);
        ext_tick = 1'b1;
        @(negedge clk);
        ext_tick = 1'b0;
    endtask

    // Tick lands one edge before the clear write's access edge.
    task automatic clear_with_tick();
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b1; paddr = 12'h01C; pwdata = 32'h1; penable = 1'b0;
        ext_tick = 1'b1;
        @(negedge clk);
        penable = 1'b1; ext_tick = 1'b0;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    initial begin
        #(CLK_PER * 100000);
        if (!done) begin
            total_cnt++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", pass_cnt, total_cnt);
            $finish;
        end
    end

    localparam logic [7:0] ID_EXP [8] = '{8'h31, 8'h10, 8'h14, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R13 reset state
        apb_read(12'h000, 32'd0, "R13 count");
        apb_read(12'h004, 32'd0, "R13 match");
        apb_read(12'h008, 32'd0, "R13 load");
        apb_read(12'h010, 32'd0, "R13 mask");
        apb_read(12'h014, 32'd0, "R13 raw");
        chk("R13 irq", {31'd0, irq}, 32'd0);

        // R12 handshake
        chk("R12 pready", {31'd0, pready}, 32'd1);
        chk("R12 pslverr", {31'd0, pslverr}, 32'd0);

        // R2 prescaler instance
        repeat (23) @(negedge clk);
        chk("R2 prescaled count a", prdata_p, cyc / PRE_DIV);
        repeat (14) @(negedge clk);
        chk("R2 prescaled count b", prdata_p, cyc / PRE_DIV);

        // R9 control
        apb_read(12'h00C, 32'd1, "R9 ctrl");
        apb_write(12'h00C, 32'd0);
        apb_read(12'h00C, 32'd1, "R9 ctrl after write");

        // R11 identification window
        for (int i = 0; i < 8; i++)
            apb_read(12'hFE0 + 12'(4 * i), {24'd0, ID_EXP[i]}, "R11 id byte");

        // R10 reads that return zero
        apb_read(12'h01C, 32'd0, "R10 clear read");
        apb_read(12'h020, 32'd0, "R10 unmapped 0x020");
        apb_read(12'h800, 32'd0, "R10 unmapped 0x800");

        // R3 load
        apb_write(12'h008, 32'd100);
        apb_read(12'h008, 32'd100, "R3 load readback");
        apb_read(12'h000, 32'd100, "R3 count after load");

        // R1 ticking
        pulse_tick(); pulse_tick(); pulse_tick();
        apb_read(12'h000, 32'd103, "R1 count after 3 ticks");

        // R10 read-only writes ignored
        apb_write(12'h000, 32'h5555);
        apb_read(12'h000, 32'd103, "R10 count write ignored");
        apb_write(12'h014, 32'h1);
        apb_read(12'h014, 32'd0, "R10 raw write ignored");
        apb_write(12'h018, 32'h1);
        apb_read(12'h018, 32'd0, "R10 masked write ignored");

        // R4 alarm via tick
        apb_write(12'h004, 32'd105);
        apb_read(12'h004, 32'd105, "R4 match readback");
        pulse_tick();
        apb_read(12'h014, 32'd0, "R4 raw before match");
        pulse_tick();
        apb_read(12'h014, 32'd1, "R4 raw at match");
        chk("R6 irq masked off", {31'd0, irq}, 32'd0);
        apb_read(12'h018, 32'd0, "R6 masked status masked off");

        // R6 mask
        apb_write(12'h010, 32'hFFFF_FFFF);
        apb_read(12'h010, 32'd1, "R6 mask keeps bit0 only");
        apb_read(12'h018, 32'd1, "R6 masked status");
        chk("R6 irq on", {31'd0, irq}, 32'd1);
        apb_write(12'h010, 32'd2);
        apb_read(12'h010, 32'd0, "R6 mask bit1 ignored");
        chk("R6 irq off", {31'd0, irq}, 32'd0);
        apb_write(12'h010, 32'd1);

        // R7 clear with zero data, then no re-fire while count holds
        apb_write(12'h01C, 32'd0);
        apb_read(12'h014, 32'd0, "R7 clear with zero data");
        chk("R7 irq after clear", {31'd0, irq}, 32'd0);
        apb_read(12'h014, 32'd0, "R4 no refire while equal");
        pulse_tick();
        apb_read(12'h014, 32'd0, "R4 no fire past match");

        // R5 immediate fire via load and via match
        apb_write(12'h008, 32'd105);
        apb_read(12'h014, 32'd1, "R5 load equals match");
        apb_write(12'h01C, 32'd1);
        apb_read(12'h014, 32'd0, "R7 clear");
        apb_write(12'h004, 32'd105);
        apb_read(12'h014, 32'd1, "R5 match equals count");
        apb_write(12'h01C, 32'd1);

        // R1 wrap
        apb_write(12'h008, 32'hFFFF_FFFF);
        pulse_tick();
        apb_read(12'h000, 32'd0, "R1 wrap to zero");

        // R8 set beats clear
        apb_write(12'h004, 32'd2);
        pulse_tick();
        apb_read(12'h014, 32'd0, "R8 raw before");
        clear_with_tick();
        apb_read(12'h000, 32'd2, "R8 count reached match");
        apb_read(12'h014, 32'd1, "R8 set wins over clear");
        apb_write(12'h01C, 32'd0);
        apb_read(12'h014, 32'd0, "R7 clear after collision");

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", pass_cnt, total_cnt);
        $finish;
    end

endmodule